// File: doc/BRIEF.md
# Two-slot VLIW integer core

This block is a small statically scheduled processor. Every cycle it fetches one 64-bit bundle from an internal instruction memory and issues both halves together. The first half (slot 0) is a register-to-register ALU operation or a conditional branch. The second half (slot 1) is a word load or a word store. Both slots read their operands from one register file that has four read ports and two write ports. Slot 1 forms its memory address with an adder of its own, separate from the slot 0 ALU.

The core has no interlocks and no forwarding, so the program must be scheduled for it. A loaded value reaches the register file one bundle late. The two slots of a bundle must not depend on each other. Slots the schedule cannot fill hold no-ops.

Program and data are written through load ports while the core is held in reset. After reset is released the core runs freely. Debug read ports show the data memory and the register file, and the effective register writes of each cycle appear on observation outputs.

Top module: `vliw_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and every register reads 0 through the debug register port. The first bundle, at address 0, issues one cycle after reset is released.
- R2: A bundle holds slot 0 in bits [63:32] and slot 1 in bits [31:0]. Instruction memory entry k holds the bundle at byte address 8*k. When no branch is taken, pc_o advances by 8 every cycle.
- R3: Slot 0 executes R-format words: opcode [31:26]=0, rs [25:21], rt [20:16], rd [15:11], shamt [10:6]=0, funct [5:0]. The funct codes are 0x21 add, 0x23 subtract (rs-rt), 0x24 and, 0x25 or, 0x26 xor, and 0x2A signed set-less-than. The result is written to rd at the end of the cycle.
- R4: Slot 1 executes I-format words (opcode, rs, rt, imm16 [15:0]): opcode 0x23 loads a word and 0x2B stores rt. The byte address is rs plus sign-extended imm16, and it selects data memory word address[..:2]. A store updates memory at the end of its cycle.
- R5: A loaded value is written to rt at the end of the cycle after the load issues. The bundle that directly follows the load still reads the old value.
- R6: Both slots read two operands each and write one result each in the same cycle.
- R7: If a slot 0 result and a load return target the same register in one cycle, only the load value is written.
- R8: Register 0 always reads 0. Writes to it are discarded and never appear on the write outputs.
- R9: The all-zero word is a no-op, and so is any word with an unlisted opcode, funct or nonzero shamt for its slot. A no-op writes no register and no memory.
- R10: In slot 0, opcode 0x04 branches if rs equals rt and 0x05 branches if they differ. The target is pc+8 plus the sign-extended imm16 times 4. A branch that is not taken goes to pc+8. Slot 1 of a branch bundle always executes.
- R11: rf_we0_o, rf_waddr0_o and rf_wdata0_o show the slot 0 register write committed in a cycle. rf_we1_o, rf_waddr1_o and rf_wdata1_o show the load-return write committed in that cycle.
- R12: A scheduled loop that loads an element, adds a scalar, stores it back, steps the pointer down by 4 and branches while the pointer is nonzero leaves every element increased by the scalar. Words outside the array are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_imem_we_i | input | 1 | Instruction memory load strobe |
| ld_imem_addr_i | input | 5 | Bundle index to load |
| ld_imem_data_i | input | 64 | Bundle to load |
| ld_dmem_we_i | input | 1 | Data memory load strobe |
| ld_dmem_addr_i | input | 5 | Data word index to load |
| ld_dmem_data_i | input | 32 | Data word to load |
| dbg_dmem_addr_i | input | 5 | Data word index to observe |
| dbg_dmem_data_o | output | 32 | Observed data word |
| dbg_reg_addr_i | input | 5 | Register to observe |
| dbg_reg_data_o | output | 32 | Observed register value |
| pc_o | output | 32 | Address of the bundle issuing this cycle |
| rf_we0_o | output | 1 | Slot 0 register write this cycle |
| rf_waddr0_o | output | 5 | Slot 0 destination |
| rf_wdata0_o | output | 32 | Slot 0 result |
| rf_we1_o | output | 1 | Load-return register write this cycle |
| rf_waddr1_o | output | 5 | Load-return destination |
| rf_wdata1_o | output | 32 | Load-return data |

## Verification
Some properties are checked on every cycle. The PC stays aligned to a bundle and steps by 8 whenever no branch is taken. Every issued load comes back on the second write port exactly one cycle later. The two write outputs never name the same register or register 0. An all-zero word in either slot commits nothing. Other behaviours can only be shown by the bench's scenarios, by comparing the committed write stream against a schedule the bench computes. These are the arithmetic results, the stale read right after a load, the collision outcome, branch targets and skipped bundles, and the final array contents of the update loop.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int INSN_W   = 32;
  localparam int BUNDLE_W = 2 * INSN_W;
  localparam int XLEN     = 32;
  localparam int REG_AW   = 5;
  localparam int NREGS    = 1 << REG_AW;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic              wr;
    logic              br;
    logic              br_ne;
    alu_op_e           op;
    logic [REG_AW-1:0] rs;
    logic [REG_AW-1:0] rt;
    logic [REG_AW-1:0] rd;
    logic [15:0]       imm;
  } s0_dec_t;

  typedef struct packed {
    logic              ld;
    logic              st;
    logic [REG_AW-1:0] rs;
    logic [REG_AW-1:0] rt;
    logic [15:0]       imm;
  } s1_dec_t;
endpackage

// File: rtl/vliw_regfile.sv
module vliw_regfile #(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  parameter int NRD   = 5,
  parameter int NWR   = 2,
  parameter int AW    = $clog2(NREGS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NRD-1:0][AW-1:0]        raddr_i,
  output logic [NRD-1:0][XLEN-1:0]      rdata_o,
  input  logic [NWR-1:0]                we_i,
  input  logic [NWR-1:0][AW-1:0]        waddr_i,
  input  logic [NWR-1:0][XLEN-1:0]      wdata_i
);
  logic [XLEN-1:0] regs_q [NREGS];

  // higher-numbered write port has priority; entry 0 is never written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 1; i < NREGS; i++) begin
        for (int w = 0; w < NWR; w++) begin
          if (we_i[w] && waddr_i[w] == AW'(i)) regs_q[i] <= wdata_i[w];
        end
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata_o[r] = regs_q[raddr_i[r]];
  end
endmodule

// File: rtl/vliw_alu.sv
module vliw_alu
  import vliw_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_SLT: y_o = W'($signed(a_i) < $signed(b_i));
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/vliw_dec_s0.sv
module vliw_dec_s0
  import vliw_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output s0_dec_t           dec_o
);
  logic [5:0] opc, funct;
  logic [4:0] shamt;
  assign opc   = insn_i[31:26];
  assign shamt = insn_i[10:6];
  assign funct = insn_i[5:0];

  always_comb begin
    dec_o       = '0;
    dec_o.rs    = insn_i[25:21];
    dec_o.rt    = insn_i[20:16];
    dec_o.rd    = insn_i[15:11];
    dec_o.imm   = insn_i[15:0];
    dec_o.op    = ALU_ADD;
    if (opc == OP_RTYPE && shamt == 5'd0) begin
      dec_o.wr = 1'b1;
      unique case (funct)
        6'h21:   dec_o.op = ALU_ADD;
        6'h23:   dec_o.op = ALU_SUB;
        6'h24:   dec_o.op = ALU_AND;
        6'h25:   dec_o.op = ALU_OR;
        6'h26:   dec_o.op = ALU_XOR;
        6'h2A:   dec_o.op = ALU_SLT;
        default: dec_o.wr = 1'b0;
      endcase
    end else if (opc == OP_BEQ || opc == OP_BNE) begin
      dec_o.br    = 1'b1;
      dec_o.br_ne = (opc == OP_BNE);
    end
  end
endmodule

// File: rtl/vliw_dec_s1.sv
module vliw_dec_s1
  import vliw_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output s1_dec_t           dec_o
);
  logic [5:0] opc;
  assign opc = insn_i[31:26];

  always_comb begin
    dec_o     = '0;
    dec_o.rs  = insn_i[25:21];
    dec_o.rt  = insn_i[20:16];
    dec_o.imm = insn_i[15:0];
    dec_o.ld  = (opc == OP_LW);
    dec_o.st  = (opc == OP_SW);
  end
endmodule

// File: rtl/vliw_core.sv
module vliw_core
  import vliw_pkg::*;
#(
  parameter int IMEM_BUNDLES = 32,
  parameter int DMEM_WORDS   = 32,
  parameter int IAW          = $clog2(IMEM_BUNDLES),
  parameter int DAW          = $clog2(DMEM_WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_imem_we_i,
  input  logic [IAW-1:0]      ld_imem_addr_i,
  input  logic [BUNDLE_W-1:0] ld_imem_data_i,
  input  logic                ld_dmem_we_i,
  input  logic [DAW-1:0]      ld_dmem_addr_i,
  input  logic [XLEN-1:0]     ld_dmem_data_i,
  input  logic [DAW-1:0]      dbg_dmem_addr_i,
  output logic [XLEN-1:0]     dbg_dmem_data_o,
  input  logic [REG_AW-1:0]   dbg_reg_addr_i,
  output logic [XLEN-1:0]     dbg_reg_data_o,
  output logic [XLEN-1:0]     pc_o,
  output logic                rf_we0_o,
  output logic [REG_AW-1:0]   rf_waddr0_o,
  output logic [XLEN-1:0]     rf_wdata0_o,
  output logic                rf_we1_o,
  output logic [REG_AW-1:0]   rf_waddr1_o,
  output logic [XLEN-1:0]     rf_wdata1_o
);
  localparam int NRD = 5;  // two per slot plus debug

  logic                run_q;
  logic [XLEN-1:0]     pc_q, pc_seq, pc_nxt;
  logic [BUNDLE_W-1:0] imem [IMEM_BUNDLES];
  logic [XLEN-1:0]     dmem [DMEM_WORDS];
  logic [BUNDLE_W-1:0] bundle;
  logic [INSN_W-1:0]   slot0_w, slot1_w;
  s0_dec_t             s0d;
  s1_dec_t             s1d;

  logic [NRD-1:0][REG_AW-1:0] rf_raddr;
  logic [NRD-1:0][XLEN-1:0]   rf_rdata;
  logic [1:0]                 rf_we;
  logic [1:0][REG_AW-1:0]     rf_waddr;
  logic [1:0][XLEN-1:0]       rf_wdata;

  logic [XLEN-1:0] alu_y, agu_addr;
  logic [DAW-1:0]  agu_idx;
  logic            br_taken, ld_fire, st_fire;
  logic            ld_v_q;
  logic [REG_AW-1:0] ld_rd_q;
  logic [XLEN-1:0] ld_data_q;
  logic            unused_bits;

  // fetch
  assign bundle  = imem[pc_q[IAW+2:3]];
  assign slot0_w = bundle[BUNDLE_W-1:INSN_W];
  assign slot1_w = bundle[INSN_W-1:0];

  vliw_dec_s0 i_dec_s0 (.insn_i(slot0_w), .dec_o(s0d));
  vliw_dec_s1 i_dec_s1 (.insn_i(slot1_w), .dec_o(s1d));

  assign rf_raddr[0] = s0d.rs;
  assign rf_raddr[1] = s0d.rt;
  assign rf_raddr[2] = s1d.rs;
  assign rf_raddr[3] = s1d.rt;
  assign rf_raddr[4] = dbg_reg_addr_i;

  vliw_regfile #(.NREGS(NREGS), .XLEN(XLEN), .NRD(NRD), .NWR(2)) i_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (rf_raddr),
    .rdata_o (rf_rdata),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata)
  );

  vliw_alu #(.W(XLEN)) i_alu (
    .op_i (s0d.op),
    .a_i  (rf_rdata[0]),
    .b_i  (rf_rdata[1]),
    .y_o  (alu_y)
  );

  // slot 1 address adder
  assign agu_addr = rf_rdata[2] + {{(XLEN-16){s1d.imm[15]}}, s1d.imm};
  assign agu_idx  = agu_addr[DAW+1:2];
  assign ld_fire  = run_q && s1d.ld;
  assign st_fire  = run_q && s1d.st;

  // branch resolution in the issue cycle
  assign br_taken = run_q && s0d.br &&
                    (s0d.br_ne ? (rf_rdata[0] != rf_rdata[1]) : (rf_rdata[0] == rf_rdata[1]));
  assign pc_seq   = pc_q + XLEN'(8);
  assign pc_nxt   = br_taken ? pc_seq + {{(XLEN-18){s0d.imm[15]}}, s0d.imm, 2'b00} : pc_seq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      run_q <= 1'b1;
      if (run_q) pc_q <= pc_nxt;
    end
  end

  // load return stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_v_q  <= 1'b0;
      ld_rd_q <= '0;
    end else begin
      ld_v_q  <= ld_fire && (s1d.rt != '0);
      ld_rd_q <= s1d.rt;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ld_imem_we_i) imem[ld_imem_addr_i] <= ld_imem_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (ld_dmem_we_i)  dmem[ld_dmem_addr_i] <= ld_dmem_data_i;
    else if (st_fire)  dmem[agu_idx]        <= rf_rdata[3];
    ld_data_q <= dmem[agu_idx];
  end

  // write resolution: load return wins, r0 dropped
  assign rf_we[1]    = ld_v_q;
  assign rf_waddr[1] = ld_rd_q;
  assign rf_wdata[1] = ld_data_q;
  assign rf_we[0]    = run_q && s0d.wr && (s0d.rd != '0) && !(ld_v_q && ld_rd_q == s0d.rd);
  assign rf_waddr[0] = s0d.rd;
  assign rf_wdata[0] = alu_y;

  assign rf_we0_o    = rf_we[0];
  assign rf_waddr0_o = rf_waddr[0];
  assign rf_wdata0_o = rf_wdata[0];
  assign rf_we1_o    = rf_we[1];
  assign rf_waddr1_o = rf_waddr[1];
  assign rf_wdata1_o = rf_wdata[1];

  assign pc_o            = pc_q;
  assign dbg_reg_data_o  = rf_rdata[4];
  assign dbg_dmem_data_o = dmem[dbg_dmem_addr_i];

  assign unused_bits = ^{pc_q[XLEN-1:IAW+3], pc_q[2:0], agu_addr[XLEN-1:DAW+2], agu_addr[1:0]};
endmodule

// File: rtl/vliw_core_chk.sv
module vliw_core_chk
  import vliw_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              br_taken_i,
  input logic [XLEN-1:0]   pc_i,
  input logic              ld_fire_i,
  input logic [REG_AW-1:0] ld_rt_i,
  input logic [INSN_W-1:0] slot0_i,
  input logic [INSN_W-1:0] slot1_i,
  input logic              st_fire_i,
  input logic              we0_i,
  input logic [REG_AW-1:0] waddr0_i,
  input logic              we1_i,
  input logic [REG_AW-1:0] waddr1_i
);
  a_r2_pc_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_i[2:0] == 3'b000);

  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !br_taken_i) |=> (pc_i == $past(pc_i) + XLEN'(8)));

  a_r5_load_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_fire_i && ld_rt_i != '0) |=> (we1_i && waddr1_i == $past(ld_rt_i)));

  a_r7_single_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we0_i && we1_i && waddr0_i == waddr1_i));

  a_r8_no_r0_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we0_i && waddr0_i == '0) && !(we1_i && waddr1_i == '0));

  a_r9_noop0_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && slot0_i == '0) |-> !we0_i);

  a_r9_noop1_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && slot1_i == '0) |-> !st_fire_i);
endmodule

bind vliw_core vliw_core_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_q),
  .br_taken_i (br_taken),
  .pc_i       (pc_q),
  .ld_fire_i  (ld_fire),
  .ld_rt_i    (s1d.rt),
  .slot0_i    (slot0_w),
  .slot1_i    (slot1_w),
  .st_fire_i  (st_fire),
  .we0_i      (rf_we0_o),
  .waddr0_i   (rf_waddr0_o),
  .we1_i      (rf_we1_o),
  .waddr1_i   (rf_waddr1_o)
);

// File: tb/test_vliw_core.sv
`timescale 1ns/1ps
module test_vliw_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_imem_we = 1'b0;
  logic [4:0]  ld_imem_addr = '0;
  logic [63:0] ld_imem_data = '0;
  logic        ld_dmem_we = 1'b0;
  logic [4:0]  ld_dmem_addr = '0;
  logic [31:0] ld_dmem_data = '0;
  logic [4:0]  dbg_dmem_addr = '0;
  logic [31:0] dbg_dmem_data;
  logic [4:0]  dbg_reg_addr = '0;
  logic [31:0] dbg_reg_data;
  logic [31:0] pc;
  logic        we0, we1;
  logic [4:0]  waddr0, waddr1;
  logic [31:0] wdata0, wdata1;

  always #2 clk = ~clk;

  vliw_core i_vliw_core (
    .clk_i(clk), .rst_ni(rst_ni),
    .ld_imem_we_i(ld_imem_we), .ld_imem_addr_i(ld_imem_addr), .ld_imem_data_i(ld_imem_data),
    .ld_dmem_we_i(ld_dmem_we), .ld_dmem_addr_i(ld_dmem_addr), .ld_dmem_data_i(ld_dmem_data),
    .dbg_dmem_addr_i(dbg_dmem_addr), .dbg_dmem_data_o(dbg_dmem_data),
    .dbg_reg_addr_i(dbg_reg_addr), .dbg_reg_data_o(dbg_reg_data),
    .pc_o(pc),
    .rf_we0_o(we0), .rf_waddr0_o(waddr0), .rf_wdata0_o(wdata0),
    .rf_we1_o(we1), .rf_waddr1_o(waddr1), .rf_wdata1_o(wdata1)
  );

  int checks = 0;
  int errors = 0;
  logic        mon_en = 1'b0;
  logic [36:0] exp_q [$];
  string       tag_q [$];

  localparam logic [31:0] NOP = 32'h0;

  function automatic logic [31:0] rr(input logic [5:0] funct, input logic [4:0] rd,
                                     input logic [4:0] rs, input logic [4:0] rt);
    return {6'h00, rs, rt, rd, 5'd0, funct};
  endfunction

  function automatic logic [31:0] ii(input logic [5:0] op, input logic [4:0] rt,
                                     input logic [4:0] rs, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [4:0] a, input logic [31:0] d, input string tag);
    exp_q.push_back({a, d});
    tag_q.push_back(tag);
  endtask

  task automatic take(input logic [4:0] a, input logic [31:0] d);
    logic [36:0] e;
    string t;
    if (exp_q.size() == 0) begin
      check(1'b0, "R11 unexpected write", {a, d}, 37'h0);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({a, d} == e, t, {a, d}, e);
    end
  endtask

  // monitor: effective register writes of each cycle, slot 0 first
  always @(negedge clk) begin
    if (mon_en) begin
      if (we0) take(waddr0, wdata0);
      if (we1) take(waddr1, wdata1);
    end
  end

  task automatic put_bundle(input int k, input logic [31:0] s0, input logic [31:0] s1);
    @(negedge clk);
    ld_imem_we = 1'b1; ld_imem_addr = 5'(k); ld_imem_data = {s0, s1};
    @(negedge clk);
    ld_imem_we = 1'b0;
  endtask

  task automatic put_word(input int idx, input logic [31:0] d);
    @(negedge clk);
    ld_dmem_we = 1'b1; ld_dmem_addr = 5'(idx); ld_dmem_data = d;
    @(negedge clk);
    ld_dmem_we = 1'b0;
  endtask

  task automatic peek_reg(input logic [4:0] r, input logic [31:0] exp, input string tag);
    dbg_reg_addr = r; #0.1;
    check(dbg_reg_data == exp, tag, {32'h0, dbg_reg_data}, {32'h0, exp});
  endtask

  task automatic peek_mem(input int idx, input logic [31:0] exp, input string tag);
    dbg_dmem_addr = 5'(idx); #0.1;
    check(dbg_dmem_data == exp, tag, {32'h0, dbg_dmem_data}, {32'h0, exp});
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected done");
    finish_run();
  end

  initial begin
    // ---------- program 1: directed operations ----------
    put_word(20, 32'h0000_00F0);
    put_word(21, 32'h0000_0F0F);
    put_word(22, 32'hFFFF_FFFE);
    put_word(23, 32'h1234_5678);
    put_word(24, 32'h0);
    put_bundle(0,  NOP, ii(6'h23, 5'd1, 5'd0, 16'd80));
    put_bundle(1,  NOP, ii(6'h23, 5'd2, 5'd0, 16'd84));
    put_bundle(2,  NOP, ii(6'h23, 5'd3, 5'd0, 16'd88));
    put_bundle(3,  rr(6'h21, 5'd4, 5'd1, 5'd2), NOP);
    put_bundle(4,  rr(6'h23, 5'd5, 5'd1, 5'd2), NOP);
    put_bundle(5,  rr(6'h24, 5'd6, 5'd1, 5'd2), NOP);
    put_bundle(6,  rr(6'h25, 5'd7, 5'd1, 5'd2), NOP);
    put_bundle(7,  rr(6'h26, 5'd8, 5'd1, 5'd3), NOP);
    put_bundle(8,  rr(6'h2A, 5'd9, 5'd3, 5'd1), NOP);
    put_bundle(9,  rr(6'h2A, 5'd10, 5'd1, 5'd3), NOP);
    put_bundle(10, NOP, ii(6'h23, 5'd11, 5'd0, 16'd92));
    put_bundle(11, rr(6'h21, 5'd12, 5'd11, 5'd1), NOP);
    put_bundle(12, rr(6'h21, 5'd13, 5'd11, 5'd0), NOP);
    put_bundle(13, NOP, ii(6'h23, 5'd14, 5'd0, 16'd80));
    put_bundle(14, rr(6'h21, 5'd14, 5'd2, 5'd2), NOP);
    put_bundle(15, rr(6'h21, 5'd0, 5'd1, 5'd1), ii(6'h23, 5'd0, 5'd0, 16'd80));
    put_bundle(16, NOP, ii(6'h2B, 5'd4, 5'd0, 16'd96));
    put_bundle(17, NOP, ii(6'h23, 5'd16, 5'd0, 16'd96));
    put_bundle(18, rr(6'h21, 5'd15, 5'd0, 5'd1), NOP);
    put_bundle(19, ii(6'h3F, 5'd17, 5'd1, 16'h0), ii(6'h3F, 5'd17, 5'd0, 16'd80));
    put_bundle(20, rr(6'h3F, 5'd17, 5'd1, 5'd2), NOP);
    put_bundle(21, ii(6'h04, 5'd2, 5'd1, 16'd2), NOP);
    put_bundle(22, rr(6'h21, 5'd18, 5'd1, 5'd0), NOP);
    put_bundle(23, ii(6'h05, 5'd2, 5'd1, 16'd2), ii(6'h23, 5'd20, 5'd0, 16'd84));
    put_bundle(24, rr(6'h21, 5'd21, 5'd1, 5'd1), NOP);
    put_bundle(25, rr(6'h21, 5'd22, 5'd2, 5'd0), NOP);
    put_bundle(26, ii(6'h04, 5'd0, 5'd0, 16'hFFFE), NOP);

    // expected commit stream (driver side of the scoreboard)
    push(5'd1,  32'h0000_00F0, "R4 load r1");
    push(5'd2,  32'h0000_0F0F, "R4 load r2");
    push(5'd4,  32'h0000_0FFF, "R6 add same cycle as load");
    push(5'd3,  32'hFFFF_FFFE, "R6 load same cycle as add");
    push(5'd5,  32'hFFFF_F1E1, "R3 subtract");
    push(5'd6,  32'h0000_0000, "R3 and");
    push(5'd7,  32'h0000_0FFF, "R3 or");
    push(5'd8,  32'hFFFF_FF0E, "R3 xor");
    push(5'd9,  32'h0000_0001, "R3 slt signed true");
    push(5'd10, 32'h0000_0000, "R3 slt signed false");
    push(5'd12, 32'h0000_00F0, "R5 stale read after load");
    push(5'd11, 32'h1234_5678, "R5 load return");
    push(5'd13, 32'h1234_5678, "R5 value visible two bundles on");
    push(5'd14, 32'h0000_00F0, "R7 load wins collision");
    push(5'd15, 32'h0000_00F0, "R8 r0 reads zero");
    push(5'd16, 32'h0000_0FFF, "R4 store then load");
    push(5'd18, 32'h0000_00F0, "R10 not taken falls through");
    push(5'd22, 32'h0000_0F0F, "R10 taken target");
    push(5'd20, 32'h0000_0F0F, "R10 branch bundle slot 1");

    // R1 reset state
    #0.1;
    check(pc == 32'h0, "R1 reset pc", {5'h0, pc}, 37'h0);
    peek_reg(5'd1, 32'h0, "R1 reset register");

    @(negedge clk);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    check(pc == 32'h0, "R1 first bundle at 0", {5'h0, pc}, 37'h0);
    run_cycles(40);
    mon_en = 1'b0;
    check(exp_q.size() == 0, "R11 stream drained", 37'(exp_q.size()), 37'h0);
    peek_reg(5'd0,  32'h0, "R8 r0 after writes");
    peek_reg(5'd14, 32'h0000_00F0, "R7 collision result");
    peek_reg(5'd17, 32'h0, "R9 no-op words wrote nothing");
    peek_reg(5'd21, 32'h0, "R10 skipped bundle");
    peek_mem(24, 32'h0000_0FFF, "R4 stored word");
    peek_mem(20, 32'h0000_00F0, "R9 no-op did not store");
    check(pc == 32'd208, "R10 self branch holds pc", {5'h0, pc}, 37'd208);
    @(negedge clk);
    check(pc == 32'd208, "R2 pc held by branch", {5'h0, pc}, 37'd208);

    // ---------- program 2: scheduled array update loop ----------
    rst_ni = 1'b0;
    #0.1;
    peek_reg(5'd4, 32'h0, "R1 registers cleared by reset");
    check(pc == 32'h0, "R1 pc cleared by reset", {5'h0, pc}, 37'h0);
    put_word(0,  32'h0000_0BAD);
    put_word(1,  32'd100);
    put_word(2,  32'd200);
    put_word(3,  32'd300);
    put_word(4,  32'd400);
    put_word(5,  32'h0000_5A5A);
    put_word(16, 32'd7);
    put_word(17, 32'hFFFF_FFFC);
    put_word(18, 32'd16);
    put_bundle(0, NOP, ii(6'h23, 5'd18, 5'd0, 16'd64));
    put_bundle(1, NOP, ii(6'h23, 5'd19, 5'd0, 16'd68));
    put_bundle(2, NOP, ii(6'h23, 5'd17, 5'd0, 16'd72));
    put_bundle(3, NOP, NOP);
    put_bundle(4, NOP, ii(6'h23, 5'd8, 5'd17, 16'd0));
    put_bundle(5, rr(6'h21, 5'd17, 5'd17, 5'd19), NOP);
    put_bundle(6, rr(6'h21, 5'd8, 5'd8, 5'd18), NOP);
    put_bundle(7, ii(6'h05, 5'd0, 5'd17, 16'hFFF8), ii(6'h2B, 5'd8, 5'd17, 16'd4));
    put_bundle(8, ii(6'h04, 5'd0, 5'd0, 16'hFFFE), NOP);
    @(negedge clk);
    rst_ni = 1'b1;
    run_cycles(80);
    peek_mem(1, 32'd107, "R12 element at 4");
    peek_mem(2, 32'd207, "R12 element at 8");
    peek_mem(3, 32'd307, "R12 element at 12");
    peek_mem(4, 32'd407, "R12 element at 16");
    peek_mem(0, 32'h0000_0BAD, "R12 word below array");
    peek_mem(5, 32'h0000_5A5A, "R12 word above array");
    peek_reg(5'd17, 32'h0, "R12 pointer reached zero");
    check(pc == 32'd64, "R12 loop exit", {5'h0, pc}, 37'd64);

    finish_run();
  end
endmodule